// File: doc/BRIEF.md
# Nibble-Wide Subroutine Return Sequencer

This block performs the return-from-subroutine step of a 4-bit microcontroller core. It holds the core's 8-bit stack pointer and the 12-bit program counter. The counter is kept as a 4-bit page register and an 8-bit step counter. When a return command arrives, the block reads three 4-bit nibbles from data memory through a synchronous read port. It rebuilds the program counter from those nibbles and then moves the stack pointer past them.

A skip select chosen with the start strobe picks between two variants. The plain return resumes at the popped address. The skip return adds one to the restored step counter, so the instruction that follows the original call is passed over. Every return takes a fixed budget of twelve clock cycles whatever the variant. Outside a return, the surrounding core can preset the stack pointer and the program counter through load ports.

Top module: `nib_return_seq`

## Requirements
- R1: After a synchronous active-high reset, busy and done are 0, and the stack pointer, page register and step counter are all 0.
- R2: While idle, sp_load writes sp_din into the stack pointer, and pc_load writes page_din into the page register and step_din into the step counter, all at the next clock edge.
- R3: In the first three cycles of a return, mem_re is high and mem_addr carries SP, SP+1 and SP+2 in that order. Each address is 8 bits modulo 256, zero-extended to the memory address width. mem_re is low in every other cycle.
- R4: Memory data is returned one cycle after its address is presented. The nibble from SP becomes step bits 3:0, the nibble from SP+1 becomes step bits 7:4, and the nibble from SP+2 becomes the page register.
- R5: Once the three nibbles are taken, the stack pointer becomes its starting value plus 3, modulo 256.
- R6: In a skip return (skip_sel = 1 at start), the restored step counter is then increased by 1. The increase wraps from 0xFF to 0x00 and leaves the page register unchanged.
- R7: In a plain return (skip_sel = 0 at start), the step counter keeps exactly the popped value.
- R8: busy rises on the clock edge that accepts start and stays high for exactly 12 cycles. done is a single-cycle pulse in the twelfth of those cycles.
- R9: start, sp_load and pc_load have no effect while busy is high.
- R10: With SP = 0xB0 and memory holding 0x6, 0x0, 0x0 at 0xB0, 0xB1, 0xB2, a skip return ends with page = 0x0, step = 0x07 and SP = 0xB3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a return when idle |
| skip_sel | input | 1 | 1 selects the skip return, 0 the plain return |
| sp_load | input | 1 | Preset the stack pointer while idle |
| sp_din | input | 8 | Stack pointer preset value |
| pc_load | input | 1 | Preset the page and step registers while idle |
| page_din | input | 4 | Page preset value |
| step_din | input | 8 | Step preset value |
| mem_re | output | 1 | Data memory read enable |
| mem_addr | output | 12 | Data memory read address |
| mem_rdata | input | 4 | Read data, valid one cycle after the address |
| busy | output | 1 | Return in progress |
| done | output | 1 | Pulses in the final cycle of a return |
| sp_q | output | 8 | Current stack pointer |
| page_q | output | 4 | Current page register |
| step_q | output | 8 | Current step counter |

## Verification
Counting from the edge that accepts start, each read is issued in cycles 0 to 2. The step nibbles are due in cycles 2 and 3. The page and the new stack pointer are due in cycle 4, and the skip increment is due in cycle 5. done appears in cycle 11, and busy falls in cycle 12. A behavioural model in the bench advances on the same edges as the design and counts those cycles as an integer offset. Every output is compared with the model at the falling edge, so each result is read in the cycle it is due and never during an edge.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
    localparam int NIB_W      = 4;
    localparam int SP_W       = 8;
    localparam int PAGE_W     = 4;
    localparam int STEP_W     = 8;
    localparam int RET_CYCLES = 12;
    localparam int POP_NIBS   = 3;
    localparam int CNT_W      = $clog2(RET_CYCLES);
    localparam int IDX_W      = $clog2(POP_NIBS);

    // per-cycle strobes issued by the sequencer
    typedef struct packed {
        logic take_lo;   // capture step[3:0]
        logic take_hi;   // capture step[7:4]
        logic take_pg;   // capture page
        logic sp_adv;    // advance stack pointer past the frame
        logic skip_inc;  // add one to step
    } pop_ctl_t;

    function automatic logic [SP_W-1:0] sp_offset(input logic [SP_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
        return base + SP_W'(idx);
    endfunction
endpackage

// File: rtl/nrs_ctrl.sv
module nrs_ctrl
    import nrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             skip_sel,
    output logic             busy,
    output logic             done,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output pop_ctl_t         ctl
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RET_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            skip_q <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                cnt    <= '0;
                skip_q <= skip_sel;
            end
        end else if (cnt == LAST) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        rd_en        = busy && (cnt < CNT_W'(POP_NIBS));
        rd_idx       = IDX_W'(cnt);
        ctl.take_lo  = busy && (cnt == CNT_W'(1));
        ctl.take_hi  = busy && (cnt == CNT_W'(2));
        ctl.take_pg  = busy && (cnt == CNT_W'(3));
        ctl.sp_adv   = busy && (cnt == CNT_W'(3));
        ctl.skip_inc = busy && skip_q && (cnt == CNT_W'(4));
        done         = busy && (cnt == LAST);
    end

    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && !done);
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && rd_en && !done));
    p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/nrs_stack.sv
module nrs_stack
    import nrs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              ld,
    input  logic [SP_W-1:0]   din,
    input  logic              adv,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SP_W-1:0]   sp_q,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)
            sp_q <= '0;
        else if (adv)
            sp_q <= sp_q + SP_W'(POP_NIBS);
        else if (ld && !busy)
            sp_q <= din;
    end

    assign addr = ADDR_W'(sp_offset(sp_q, rd_idx));

    p_sp_plus3_r5: assert property (@(posedge clk) disable iff (rst)
        adv |=> sp_q == $past(sp_q) + SP_W'(3));
    p_sp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !adv) |=> $stable(sp_q));
endmodule

// File: rtl/nrs_pcreg.sv
module nrs_pcreg
    import nrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              ld,
    input  logic [PAGE_W-1:0] page_din,
    input  logic [STEP_W-1:0] step_din,
    input  pop_ctl_t          ctl,
    input  logic [NIB_W-1:0]  rdata,
    output logic [PAGE_W-1:0] page_q,
    output logic [STEP_W-1:0] step_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            step_q <= '0;
        end else if (busy) begin
            if (ctl.take_lo)  step_q[NIB_W-1:0]       <= rdata;
            if (ctl.take_hi)  step_q[STEP_W-1:NIB_W]  <= rdata;
            if (ctl.take_pg)  page_q                  <= PAGE_W'(rdata);
            if (ctl.skip_inc) step_q                  <= step_q + STEP_W'(1);
        end else if (ld) begin
            page_q <= page_din;
            step_q <= step_din;
        end
    end

    p_low_nib_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.take_lo |=> step_q[NIB_W-1:0] == $past(rdata));
    p_page_nib_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.take_pg |=> page_q == $past(rdata));
    p_skip_inc_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.skip_inc |=> (step_q == $past(step_q) + STEP_W'(1)) && $stable(page_q));
endmodule

// File: rtl/nib_return_seq.sv
module nib_return_seq
    import nrs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              skip_sel,
    input  logic              sp_load,
    input  logic [SP_W-1:0]   sp_din,
    input  logic              pc_load,
    input  logic [PAGE_W-1:0] page_din,
    input  logic [STEP_W-1:0] step_din,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [SP_W-1:0]   sp_q,
    output logic [PAGE_W-1:0] page_q,
    output logic [STEP_W-1:0] step_q
);
    pop_ctl_t         ctl;
    logic [IDX_W-1:0] rd_idx;

    nrs_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .skip_sel(skip_sel),
        .busy(busy), .done(done), .rd_en(mem_re), .rd_idx(rd_idx), .ctl(ctl)
    );

    nrs_stack #(.ADDR_W(ADDR_W)) u_stack (
        .clk(clk), .rst(rst), .busy(busy), .ld(sp_load), .din(sp_din),
        .adv(ctl.sp_adv), .rd_idx(rd_idx), .sp_q(sp_q), .addr(mem_addr)
    );

    nrs_pcreg u_pc (
        .clk(clk), .rst(rst), .busy(busy), .ld(pc_load),
        .page_din(page_din), .step_din(step_din), .ctl(ctl),
        .rdata(mem_rdata), .page_q(page_q), .step_q(step_q)
    );

    p_read_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> busy && !done);
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_re && $past(mem_re)) |-> mem_addr[SP_W-1:0] == $past(mem_addr[SP_W-1:0]) + SP_W'(1));
endmodule

// File: tb/sim_nib_return_seq.sv
module sim_nib_return_seq;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, skip_sel = 0, sp_load = 0, pc_load = 0;
    logic [7:0]  sp_din = 0, step_din = 0;
    logic [3:0]  page_din = 0;
    logic        mem_re, busy, done;
    logic [11:0] mem_addr;
    logic [3:0]  mem_rdata = 0;
    logic [7:0]  sp_q, step_q;
    logic [3:0]  page_q;

    logic [3:0] mem [256];

    int checks = 0, fails = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    nib_return_seq u0 (
        .clk(clk), .rst(rst), .start(start), .skip_sel(skip_sel),
        .sp_load(sp_load), .sp_din(sp_din), .pc_load(pc_load),
        .page_din(page_din), .step_din(step_din), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .sp_q(sp_q), .page_q(page_q), .step_q(step_q)
    );

    always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr[7:0]];

    // behavioural reference model
    bit         m_busy = 0, m_skip = 0;
    int         m_t = 0;
    logic [7:0] m_sp = 0, m_step = 0;
    logic [3:0] m_page = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_t = 0; m_sp = 0; m_step = 0; m_page = 0;
        end else if (m_busy) begin
            if (m_t == 1) m_step[3:0] = mem[m_sp];
            if (m_t == 2) m_step[7:4] = mem[8'(m_sp + 8'd1)];
            if (m_t == 3) begin
                m_page = mem[8'(m_sp + 8'd2)];
                m_sp   = m_sp + 8'd3;
            end
            if (m_t == 4 && m_skip) m_step = m_step + 8'd1;
            if (m_t == 11) begin m_busy = 0; m_t = 0; end
            else m_t++;
        end else begin
            if (sp_load) m_sp = sp_din;
            if (pc_load) begin m_page = page_din; m_step = step_din; end
            if (start) begin m_busy = 1; m_t = 0; m_skip = skip_sel; end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R8", "busy", busy, m_busy);
            check("R8", "done", done, (m_busy && m_t == 11));
            check("R3", "mem_re", mem_re, (m_busy && m_t < 3));
            if (m_busy && m_t < 3)
                check("R3", "mem_addr", mem_addr, {4'h0, 8'(m_sp + 8'(m_t))});
            check("R5", "sp", sp_q, m_sp);
            check("R4", "page", page_q, m_page);
            check("R4", "step", step_q, m_step);
        end
    end

    task automatic preset(input logic [7:0] sp, input logic [3:0] pg, input logic [7:0] st);
        @(negedge clk);
        sp_load = 1; sp_din = sp; pc_load = 1; page_din = pg; step_din = st;
        @(negedge clk);
        sp_load = 0; pc_load = 0;
    endtask

    task automatic run_return(input bit skip, output int busy_cycles);
        int n = 0;
        @(negedge clk);
        start = 1; skip_sel = skip;
        @(negedge clk);
        start = 0;
        while (busy && n < 40) begin
            n++;
            @(negedge clk);
        end
        busy_cycles = n;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int bc;
        for (int i = 0; i < 256; i++) mem[i] = 4'(i * 7 + 3);
        repeat (3) @(negedge clk);
        check("R1", "busy after reset", busy, 0);
        check("R1", "done after reset", done, 0);
        check("R1", "sp after reset", sp_q, 0);
        check("R1", "page after reset", page_q, 0);
        check("R1", "step after reset", step_q, 0);
        rst = 0;

        // R2 preset and R10 worked example
        mem[8'hB0] = 4'h6; mem[8'hB1] = 4'h0; mem[8'hB2] = 4'h0;
        preset(8'hB0, 4'hA, 8'h5C);
        check("R2", "sp preset", sp_q, 8'hB0);
        check("R2", "page preset", page_q, 4'hA);
        check("R2", "step preset", step_q, 8'h5C);
        run_return(1'b1, bc);
        check("R8", "busy length", bc, 12);
        check("R10", "page", page_q, 4'h0);
        check("R10", "step", step_q, 8'h07);
        check("R10", "sp", sp_q, 8'hB3);

        // R7 plain return keeps popped value
        mem[8'h40] = 4'hF; mem[8'h41] = 4'hF; mem[8'h42] = 4'h5;
        preset(8'h40, 4'h1, 8'h11);
        run_return(1'b0, bc);
        check("R7", "step no add", step_q, 8'hFF);
        check("R7", "page", page_q, 4'h5);
        check("R5", "sp", sp_q, 8'h43);

        // R6 wrap of step, R5/R3 wrap of stack pointer
        mem[8'hFE] = 4'hF; mem[8'hFF] = 4'hF; mem[8'h00] = 4'h9;
        preset(8'hFE, 4'h2, 8'h22);
        run_return(1'b1, bc);
        check("R6", "step wrap", step_q, 8'h00);
        check("R6", "page untouched by increment", page_q, 4'h9);
        check("R5", "sp wrap", sp_q, 8'h01);

        // R9 start and loads while busy are ignored
        mem[8'h60] = 4'h3; mem[8'h61] = 4'h8; mem[8'h62] = 4'hC;
        preset(8'h60, 4'h0, 8'h00);
        @(negedge clk);
        start = 1; skip_sel = 0;
        @(negedge clk);
        start = 0;
        repeat (4) @(negedge clk);
        start = 1; skip_sel = 1; sp_load = 1; sp_din = 8'h10;
        pc_load = 1; page_din = 4'h7; step_din = 8'h77;
        @(negedge clk);
        start = 0; sp_load = 0; pc_load = 0;
        repeat (7) @(negedge clk);
        check("R9", "busy ends on time", busy, 0);
        check("R9", "step unaffected", step_q, 8'h83);
        check("R9", "page unaffected", page_q, 4'hC);
        check("R9", "sp unaffected", sp_q, 8'h63);
        repeat (3) @(negedge clk);
        check("R9", "no second return", busy, 0);

        finish_run();
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule